// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a memory read port and an instruction consumer. It fetches code bytes ahead of the consumer and holds them in a small first-in-first-out store with six slots. Each read address is formed from a code segment base and a 16-bit fetch pointer. The pointer advances by one every time memory accepts a request, so the block fills itself without any command from the consumer. The consumer takes bytes one at a time through a valid/ready handshake. The queue can be filled and drained in the same cycle.

A redirect is signalled by raising `flush` for one cycle with a new pointer value on `flush_ip`. The queue is emptied at once and fetching restarts from the new pointer. Reads already in flight when the redirect arrives still return their data, but that data is silently dropped. Memory accepts a request when `mem_req` and `mem_ack` are both high. Read data comes back in request order, no earlier than the cycle after acceptance, one byte per cycle in which `mem_rvalid` is high.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held and right after its release, the queue is empty (`out_valid` low) and the fetch pointer equals the reset value 0x0000.
- R2: `mem_addr` equals (`cs_base` × 16 + pointer) modulo 2^20, so a sum above 0xFFFFF wraps to the low end of the 20-bit space.
- R3: The pointer rises by one for each accepted request (`mem_req` and `mem_ack` high at a clock edge). It wraps from 0xFFFF to 0x0000 without carrying into the segment.
- R4: `mem_req` is high exactly when `flush` is low and the sum of queued bytes and reads still in flight is below six. Reads in flight include those that will be discarded. The queue never holds more than six bytes.
- R5: Bytes reach `out_byte` in the order their addresses were requested. One byte leaves for each cycle in which `out_valid` and `out_ready` are both high.
- R6: A byte may be written into the queue and another taken out in the same cycle. With memory answering at once and the consumer always ready, the block sustains one byte per cycle.
- R7: A cycle with `flush` high holds `mem_req` low. The next cycle the queue is empty and the pointer equals the `flush_ip` value. A consumer handshake in the flush cycle has no effect.
- R8: Read data for any request accepted before a flush is discarded and never reaches `out_byte`. This includes data returned in the flush cycle itself.
- R9: `out_valid` is low whenever the queue holds no byte.
- R10: `out_ready` while `out_valid` is low removes nothing from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_base | input | 16 | Code segment base, shifted left by 4 in the address |
| flush | input | 1 | Redirect: empty the queue and reload the pointer |
| flush_ip | input | 16 | New pointer value loaded on flush |
| mem_req | output | 1 | Read request is being offered |
| mem_addr | output | 20 | Physical byte address of the offered request |
| mem_ack | input | 1 | Memory accepts the offered request this cycle |
| mem_rvalid | input | 1 | A read byte is returned this cycle, in request order |
| mem_rdata | input | 8 | Returned read byte |
| out_valid | output | 1 | A byte is available to the consumer |
| out_byte | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Consumer takes the byte this cycle |

## Verification
Memory in the bench returns a hash of each address, so a byte from the wrong address, a reordered byte or a stale byte all show up as a data mismatch. Random runs mix acceptance rates, return latencies, consumer stalls and redirects. These show whether the request gating counts in-flight reads correctly under back-pressure. Directed cases separate three address faults: a pointer that wraps from 0xFFFF, a segment-plus-pointer sum that wraps past 20 bits, and a carry that leaks from pointer to segment. A burst of six reads left in flight across a redirect tests stale-data discard in isolation. A full-speed run with no stalls checks that a write and a read in the same cycle sustain one byte per cycle.

// File: rtl/pfq_pkg.sv
// Shared helpers for the prefetch queue.
// Assumes: counts are non-negative and fit in 32 bits.
package pfq_pkg;

    // Bits needed to hold the values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pfq_addr_gen.sv
// Fetch pointer and physical address former.
// Holds the pointer, loads it on flush, and advances it on each accepted
// request. The address is the segment shifted left plus the pointer,
// truncated to ADDR_W bits.
// Assumes: flush takes precedence over advance in the same cycle.
module pfq_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int IP_W      = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20,
    parameter logic [IP_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_base,
    input  logic              flush,
    input  logic [IP_W-1:0]   flush_ip,
    input  logic              advance,
    output logic [ADDR_W-1:0] fetch_addr
);

    logic [IP_W-1:0]   ip_q;
    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] ip_ext;

    // Pointer register: reset value, redirect load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)       ip_q <= RESET_IP;
        else if (flush)   ip_q <= flush_ip;
        else if (advance) ip_q <= ip_q + 1'b1;
    end

    // Segment-scaled base plus zero-extended pointer, modulo 2^ADDR_W.
    always_comb begin
        seg_ext    = ADDR_W'(seg_base) << SEG_SHIFT;
        ip_ext     = ADDR_W'(ip_q);
        fetch_addr = seg_ext + ip_ext;
    end

    // R3
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !flush) |=> (ip_q == IP_W'($past(ip_q) + 1'b1)));

    // R7
    flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ip_q == $past(flush_ip)));

endmodule

// File: rtl/pfq_ring.sv
// Circular byte store with DEPTH slots (DEPTH need not be a power of two).
// Push and pop may coincide. Clear empties the store and wins over both.
// Assumes: the caller never pushes into a full store or pops an empty one.
module pfq_ring #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);

    localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [DEPTH-1:0][DATA_W-1:0] slots;
    logic [IDX_W-1:0]             wr_ptr;
    logic [IDX_W-1:0]             rd_ptr;

    // Step an index by one, folding back to zero after the last slot.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot storage: write the incoming byte at the write index.
    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (push && !clear && wr_ptr == IDX_W'(s)) slots[s] <= push_data;
        end
    end

    // Index and fill-count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head byte and emptiness.
    always_comb begin
        pop_data = slots[rd_ptr];
        empty    = (count == '0);
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear) |-> (count < CNT_W'(DEPTH)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/pfq_tracker.sv
// Read budget keeper. Counts live reads (data will be kept) and doomed reads
// (accepted before a flush, data will be dropped). A new read is allowed
// only when queued + live + doomed stays below DEPTH.
// Assumes: memory returns data in request order and never without a
// matching outstanding read.
module pfq_tracker #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             issue,
    input  logic             rvalid,
    input  logic [CNT_W-1:0] q_count,
    output logic             may_issue,
    output logic             keep_data
);

    localparam int SUM_W = CNT_W + 2;

    logic [CNT_W-1:0] live_q, live_d;
    logic [CNT_W-1:0] doom_q, doom_d;
    logic [SUM_W-1:0] budget;
    logic             ret_any;

    // Budget in use, issue permission, and keep/drop of the returning byte.
    always_comb begin
        budget    = SUM_W'(q_count) + SUM_W'(live_q) + SUM_W'(doom_q);
        may_issue = !flush && (budget < SUM_W'(DEPTH));
        ret_any   = rvalid && ((live_q != '0) || (doom_q != '0));
        keep_data = rvalid && !flush && (doom_q == '0);
    end

    // Next counts: a flush dooms all live reads; returns retire doomed first.
    always_comb begin
        live_d = live_q;
        doom_d = doom_q;
        if (flush) begin
            doom_d = doom_q + live_q - CNT_W'(ret_any);
            live_d = '0;
        end else begin
            if (ret_any) begin
                if (doom_q != '0) doom_d = doom_q - 1'b1;
                else              live_d = live_q - 1'b1;
            end
            if (issue) live_d = live_d + 1'b1;
        end
    end

    // Count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            doom_q <= '0;
        end else begin
            live_q <= live_d;
            doom_q <= doom_d;
        end
    end

    // R4
    budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        budget <= SUM_W'(DEPTH));

    // R8
    doomed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && doom_q != '0) |-> !keep_data);

endmodule

// File: rtl/prefetch_queue.sv
// Instruction prefetch byte queue: fetches code bytes ahead of the consumer
// from segment-relative addresses and hands them out one per handshake.
// Assumes: read data returns in order, at least one cycle after acceptance;
// cs_base changes only together with a flush.
module prefetch_queue #(
    parameter int BYTE_W    = 8,
    parameter int DEPTH     = 6,
    parameter int SEG_W     = 16,
    parameter int IP_W      = 16,
    parameter int SEG_SHIFT = 4,
    parameter logic [IP_W-1:0] RESET_IP = '0,
    localparam int ADDR_W = ((SEG_W + SEG_SHIFT) > IP_W) ? (SEG_W + SEG_SHIFT) : IP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  cs_base,
    input  logic              flush,
    input  logic [IP_W-1:0]   flush_ip,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    input  logic              out_ready
);

    localparam int CNT_W = pfq_pkg::cnt_w(DEPTH);

    logic             issue;
    logic             keep_data;
    logic             may_issue;
    logic             pop;
    logic             q_empty;
    logic [CNT_W-1:0] q_count;

    // Handshake decode at the block edges.
    always_comb begin
        mem_req   = may_issue;
        issue     = may_issue && mem_ack;
        out_valid = !q_empty;
        pop       = out_valid && out_ready && !flush;
    end

    pfq_addr_gen #(
        .SEG_W(SEG_W), .IP_W(IP_W), .SEG_SHIFT(SEG_SHIFT),
        .ADDR_W(ADDR_W), .RESET_IP(RESET_IP)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .seg_base(cs_base), .flush(flush),
        .flush_ip(flush_ip), .advance(issue), .fetch_addr(mem_addr)
    );

    pfq_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush), .issue(issue),
        .rvalid(mem_rvalid), .q_count(q_count),
        .may_issue(may_issue), .keep_data(keep_data)
    );

    pfq_ring #(.DEPTH(DEPTH), .DATA_W(BYTE_W), .CNT_W(CNT_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .clear(flush), .push(keep_data),
        .push_data(mem_rdata), .pop(pop), .pop_data(out_byte),
        .count(q_count), .empty(q_empty)
    );

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R7
    flush_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !mem_req);

endmodule

// File: tb/prefetch_queue_tb.sv
`timescale 1ns/1ps
module prefetch_queue_tb;

    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cs_base;
    logic        flush;
    logic [15:0] flush_ip;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack;
    logic        mem_rvalid;
    logic [7:0]  mem_rdata;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int pops   = 0;

    logic [19:0] pend_addr[$];
    bit          pend_stale[$];
    int          model_q;
    logic [15:0] exp_req_ip;
    logic [15:0] exp_pop_ip;

    always #5 clk = ~clk;

    prefetch_queue u_dut (
        .clk(clk), .rst_n(rst_n), .cs_base(cs_base), .flush(flush),
        .flush_ip(flush_ip), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready)
    );

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] ip);
        return {seg, 4'h0} + {4'h0, ip};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check, update the model for the next edge.
    task automatic step(input bit do_flush, input logic [15:0] nip, input logic [15:0] ncs,
                        input int ack_pct, input int rv_pct, input int rdy_pct);
        bit stale;
        bit did_pop;
        @(negedge clk);
        flush    = do_flush;
        flush_ip = nip;
        if (do_flush) cs_base = ncs;
        mem_ack    = ($urandom % 100) < ack_pct;
        mem_rvalid = (pend_addr.size() > 0) && (($urandom % 100) < rv_pct);
        mem_rdata  = mem_rvalid ? mem_byte(pend_addr[0]) : 8'h00;
        out_ready  = ($urandom % 100) < rdy_pct;
        #1;
        // R9: valid tracks model occupancy
        check(out_valid == (model_q != 0), "R9 out_valid", 32'(out_valid), 32'(model_q != 0));
        if (do_flush)
            check(!mem_req, "R7 req during flush", 32'(mem_req), 0);
        else
            check(mem_req == ((model_q + pend_addr.size()) < DEPTH), "R4 req gating",
                  32'(mem_req), 32'((model_q + pend_addr.size()) < DEPTH));
        if (mem_req)
            check(mem_addr == phys(cs_base, exp_req_ip), "R2 R3 address",
                  32'(mem_addr), 32'(phys(cs_base, exp_req_ip)));
        did_pop = out_valid && out_ready && !do_flush;
        if (did_pop)
            check(out_byte == mem_byte(phys(cs_base, exp_pop_ip)), "R5 R8 R10 byte order",
                  32'(out_byte), 32'(mem_byte(phys(cs_base, exp_pop_ip))));
        if (mem_rvalid) begin
            stale = pend_stale[0] || do_flush;
            void'(pend_addr.pop_front());
            void'(pend_stale.pop_front());
            if (!stale) model_q++;
        end
        if (do_flush) begin
            foreach (pend_stale[i]) pend_stale[i] = 1'b1;
            model_q    = 0;
            exp_req_ip = nip;
            exp_pop_ip = nip;
        end else begin
            if (did_pop) begin
                model_q--;
                exp_pop_ip++;
                pops++;
            end
            if (mem_req && mem_ack) begin
                pend_addr.push_back(mem_addr);
                pend_stale.push_back(1'b0);
                exp_req_ip++;
            end
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int p0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_base = 16'h0100; flush = 1'b0; flush_ip = '0;
        mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; out_ready = 1'b1;
        model_q = 0; exp_req_ip = 16'h0000; exp_pop_ip = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: empty and pointer at reset value while held in reset
        check(!out_valid, "R1 valid in reset", 32'(out_valid), 0);
        check(mem_addr == phys(cs_base, 16'h0000), "R1 reset pointer", 32'(mem_addr),
              32'(phys(cs_base, 16'h0000)));
        rst_n = 1'b1;
        #1;
        check(!out_valid, "R1 valid after release", 32'(out_valid), 0);

        // Random mix of rates, stalls and redirects.
        for (int i = 0; i < 3000; i++) begin
            bit fl = ($urandom % 100) < 2;
            step(fl, 16'($urandom), 16'($urandom), 40 + ($urandom % 61),
                 20 + ($urandom % 81), $urandom % 101);
        end

        // R3: pointer wrap from 0xFFFF without carry into segment.
        step(1'b1, 16'hFFFD, 16'h1234, 100, 50, 0);
        for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 100, 70, 60);

        // R2: address sum wraps past 20 bits.
        step(1'b1, 16'h0020, 16'hFFFF, 100, 50, 0);
        for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 100, 70, 60);

        // R8: six reads left in flight across a redirect, then returned.
        step(1'b1, 16'h0100, 16'h2000, 100, 0, 0);
        for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 100, 0, 0);
        check(pend_addr.size() == DEPTH, "R4 R8 in-flight fill", 32'(pend_addr.size()), DEPTH);
        step(1'b1, 16'h0400, 16'h2000, 100, 100, 100);
        for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 100, 100, 100);

        // R6: one byte per cycle at full speed.
        step(1'b1, 16'h0800, 16'h0300, 100, 100, 100);
        for (int i = 0; i < 10; i++) step(1'b0, 0, 0, 100, 100, 100);
        p0 = pops;
        for (int i = 0; i < 50; i++) step(1'b0, 0, 0, 100, 100, 100);
        check((pops - p0) >= 48, "R6 throughput", 32'(pops - p0), 48);

        // R10: ready with empty queue removes nothing; drain afterwards.
        step(1'b1, 16'h0900, 16'h0300, 0, 100, 100);
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 100, 100);
        check(!out_valid, "R10 empty stays empty", 32'(out_valid), 0);
        for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 100, 100, 100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule